// File: doc/BRIEF.md
# FIFO-Gated Burst Request Planner

This block sits on the fetch side of a display-layer DMA channel. It is given a transfer as a base address and a beat count. It cuts that transfer into system-bus read requests, one at a time. Each request carries a start address, a burst type and a beat count. A programmed burst-length code picks the preferred burst size. A request is raised only when the local receive FIFO has room for a whole burst of that size.

While the transfer has at least a full preferred burst left, every request uses the preferred size. At the tail the size steps down through the smaller incrementing bursts, and the last one to three beats go out as single-beat requests. The burst-length code sits in a small configuration register. A write to it is dropped while a write-protect input is high.

Only one request is outstanding at a time. After a request is acknowledged, the block waits until every beat of that burst has been delivered into the FIFO before it plans the next one. A one-cycle done pulse marks the acknowledge of the final request of a transfer.

Top module: `burst_planner`

## Requirements
- R1: The burst code maps to request type and length as follows: code 0 gives type 0 with 1 beat, 1 gives type 1 with 4 beats, 2 gives type 2 with 8 beats, 3 gives type 3 with 16 beats, and 4 gives type 4 with 32 beats. `req_len` always equals the length of `req_type`. Codes 5 to 7 behave as code 0.
- R2: After reset, `cfg_code` is 0 and `req`, `xfer_busy` and `xfer_done` are low.
- R3: `cfg_we` loads `cfg_wdata` into `cfg_code` on the next edge when `cfg_lock` is low. When `cfg_lock` is high, the write leaves `cfg_code` unchanged.
- R4: `xfer_start` is taken only while `xfer_busy` is low and `xfer_beats` is non-zero. Otherwise it has no effect. `req` is never high while `xfer_busy` is low.
- R5: A request is raised only when `DEPTH - fifo_level` is at least the burst length selected by `cfg_code`.
- R6: While the beats remaining are at least the selected burst length, each request uses the selected type.
- R7: When fewer beats remain than the selected length, the request uses the largest of 16, 8 or 4 beats (not above the selected size) that fits the remainder. Below 4 beats remaining, single-beat requests are used.
- R8: The first request address is the transfer base address. Each later address is the previous one plus `req_len*BPW`.
- R9: Once raised, `req` stays high with stable address, type and length until the cycle `bus_ack` is high.
- R10: After an acknowledge, no new request is raised until `req_len` `fill_beat` pulses have been received.
- R11: `xfer_done` is a one-cycle pulse in the cycle after the acknowledge of the request that carries the last beats of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lock | input | 1 | Write protect; high drops configuration writes |
| cfg_wdata | input | 3 | Burst code to write |
| cfg_code | output | 3 | Current burst code |
| xfer_start | input | 1 | Start a transfer |
| xfer_beats | input | CW | Beats in the transfer |
| xfer_addr | input | AW | Transfer base address |
| xfer_busy | output | 1 | Transfer in progress |
| xfer_done | output | 1 | Pulse after the final request is acknowledged |
| fifo_level | input | LVW | Words currently held in the receive FIFO |
| fill_beat | input | 1 | One requested beat written into the FIFO |
| req | output | 1 | Bus read request |
| bus_ack | input | 1 | Request accepted |
| req_addr | output | AW | Request start address |
| req_type | output | 3 | Burst type, encoded as in R1 |
| req_len | output | 6 | Beats in the request |

## Verification
An accepted start loads the transfer on one edge. The first `req` is raised on the following edge, provided the FIFO gate allows it. `xfer_done` and the updated address appear on the edge that samples `bus_ack`. After the last `fill_beat` of a burst, one edge clears the pending count and the next edge raises the following request, so `req` shows up two cycles later. The bench drives inputs on falling edges and samples on falling edges. For request arrival it polls `req` with a bounded wait. For the gate and pending-beat cases it checks fixed cycle counts: `req` must stay low over a window, then appear exactly when the timing above predicts.

// File: rtl/burst_planner.sv
module burst_planner #(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 64,
  parameter int BPW   = 4,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_lock,
  input  logic [2:0]    cfg_wdata,
  output logic [2:0]    cfg_code,
  input  logic          xfer_start,
  input  logic [CW-1:0] xfer_beats,
  input  logic [AW-1:0] xfer_addr,
  output logic          xfer_busy,
  output logic          xfer_done,
  input  logic [LVW-1:0] fifo_level,
  input  logic          fill_beat,
  output logic          req,
  input  logic          bus_ack,
  output logic [AW-1:0] req_addr,
  output logic [2:0]    req_type,
  output logic [5:0]    req_len
);
  logic [CW-1:0] rem;
  logic [5:0]    pend;
  logic [2:0]    nxt_t;
  logic [5:0]    nxt_len;

  wire [2:0] sel      = (cfg_code > 3'd4) ? 3'd0 : cfg_code;
  wire [5:0] sel_sz   = (sel == 3'd0) ? 6'd1 : (6'd1 << (sel + 3'd1));
  wire       space_ok = (int'(fifo_level) + int'(sel_sz)) <= DEPTH;
  wire       idle     = (rem == '0) && (pend == '0) && !req;
  wire       issue    = !req && (rem != '0) && (pend == '0) && space_ok;

  always_comb begin
    nxt_t = 3'd0;
    for (int k = 1; k <= 4; k++)
      if (3'(k) <= sel && rem >= CW'(1 << (k + 1))) nxt_t = 3'(k);
    nxt_len = (nxt_t == 3'd0) ? 6'd1 : (6'd1 << (nxt_t + 3'd1));
  end

  assign xfer_busy = !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_code  <= '0;
      rem       <= '0;
      pend      <= '0;
      req       <= 1'b0;
      req_addr  <= '0;
      req_type  <= '0;
      req_len   <= '0;
      xfer_done <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      if (cfg_we && !cfg_lock) cfg_code <= cfg_wdata;
      if (xfer_start && idle && xfer_beats != '0) begin
        rem      <= xfer_beats;
        req_addr <= xfer_addr;
      end
      if (issue) begin
        req      <= 1'b1;
        req_type <= nxt_t;
        req_len  <= nxt_len;
      end
      if (req && bus_ack) begin
        req       <= 1'b0;
        rem       <= rem - CW'(req_len);
        req_addr  <= req_addr + AW'(req_len) * AW'(BPW);
        pend      <= req_len;
        xfer_done <= (rem == CW'(req_len));
      end else if (fill_beat && pend != '0) begin
        pend <= pend - 6'd1;
      end
    end
  end
endmodule

module burst_planner_chk #(
  parameter int AW    = 32,
  parameter int DEPTH = 64,
  parameter int LVW   = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic           cfg_lock,
  input logic [2:0]     cfg_code,
  input logic           xfer_busy,
  input logic           xfer_done,
  input logic [LVW-1:0] fifo_level,
  input logic           req,
  input logic           bus_ack,
  input logic [AW-1:0]  req_addr,
  input logic [2:0]     req_type,
  input logic [5:0]     req_len
);
  function automatic int sz(input logic [2:0] c);
    return (c == 3'd0 || c > 3'd4) ? 1 : (1 << (int'(c) + 1));
  endfunction

  p_len_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (req_type <= 3'd4 && int'(req_len) == sz(req_type)));
  p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_lock) |=> $stable(cfg_code));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> !req);
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> (int'($past(fifo_level)) + sz($past(cfg_code)) <= DEPTH));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !bus_ack) |=> (req && $stable(req_addr) && $stable(req_type) && $stable(req_len)));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(req && bus_ack));
endmodule

bind burst_planner burst_planner_chk #(.AW(AW), .DEPTH(DEPTH), .LVW(LVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lock(cfg_lock), .cfg_code(cfg_code),
  .xfer_busy(xfer_busy), .xfer_done(xfer_done), .fifo_level(fifo_level), .req(req),
  .bus_ack(bus_ack), .req_addr(req_addr), .req_type(req_type), .req_len(req_len));

// File: tb/test_burst_planner.sv
module test_burst_planner;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, CW = 16, DEPTH = 64, BPW = 4;
  localparam int LVW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [2:0]  code;
    logic [15:0] beats;
    logic [31:0] base;
    logic [7:0]  nreq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd3, 16'd45, 32'h1000, 8'd5},
    '{3'd4, 16'd63, 32'h2000, 8'd7},
    '{3'd1, 16'd6,  32'h3000, 8'd3},
    '{3'd0, 16'd3,  32'h4000, 8'd3},
    '{3'd2, 16'd8,  32'h5000, 8'd1},
    '{3'd6, 16'd2,  32'h6000, 8'd2},
    '{3'd4, 16'd31, 32'h7000, 8'd6}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_lock = 0, xfer_start = 0, fill_beat = 0, bus_ack = 0;
  logic [2:0] cfg_wdata = 0;
  logic [CW-1:0] xfer_beats = 0;
  logic [AW-1:0] xfer_addr = 0;
  logic [LVW-1:0] fifo_level = 0;
  logic [2:0] cfg_code, req_type;
  logic xfer_busy, xfer_done, req;
  logic [AW-1:0] req_addr;
  logic [5:0] req_len;

  int total = 0, bad = 0;

  burst_planner #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .BPW(BPW)) i_burst_planner (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_type(input logic [2:0] code, input int rem);
    int s = (code > 3'd4) ? 0 : int'(code);
    for (int k = s; k >= 1; k--) if (rem >= (1 << (k + 1))) return k;
    return 0;
  endfunction

  task automatic write_code(input logic [2:0] c, input logic lock);
    cfg_we = 1; cfg_wdata = c; cfg_lock = lock;
    @(negedge clk);
    cfg_we = 0; cfg_lock = 0;
  endtask

  task automatic start(input int beats, input logic [31:0] base);
    xfer_start = 1; xfer_beats = CW'(beats); xfer_addr = base;
    @(negedge clk);
    xfer_start = 0;
  endtask

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      if (req) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      fill_beat = 1; @(negedge clk); fill_beat = 0;
    end
  endtask

  task automatic ack_once;
    bus_ack = 1; @(negedge clk); bus_ack = 0;
  endtask

  task automatic run_xfer(input vec_t v);
    int rem, n, et, el;
    logic [31:0] a;
    bit seen;
    write_code(v.code, 1'b0);
    chk(cfg_code == v.code, "R3 code write", cfg_code, v.code);
    start(int'(v.beats), v.base);
    rem = int'(v.beats); a = v.base; n = 0;
    while (rem > 0) begin
      wait_req(seen);
      chk(seen, "R5 request raised", seen, 1);
      if (!seen) return;
      et = exp_type(v.code, rem);
      el = (et == 0) ? 1 : (1 << (et + 1));
      chk(req_type == 3'(et), (rem >= el && et == exp_type(v.code, 1000)) ? "R6 type" : "R7 tail type", req_type, et);
      chk(req_len == 6'(el), "R1 length", req_len, el);
      chk(req_addr == a, "R8 address", req_addr, a);
      @(negedge clk);
      chk(req && req_addr == a, "R9 held until ack", req, 1);
      ack_once();
      chk(xfer_done == (rem == el), "R11 done pulse", xfer_done, rem == el);
      rem -= el; a += 32'(el * BPW); n++;
      feed(el);
      chk(!xfer_done, "R11 done single cycle", xfer_done, 0);
    end
    chk(n == int'(v.nreq), "R6 R7 request count", n, v.nreq);
    @(negedge clk);
    chk(!xfer_busy, "R4 idle after transfer", xfer_busy, 0);
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk(cfg_code == 3'd0, "R2 reset code", cfg_code, 0);
    chk(!req && !xfer_busy && !xfer_done, "R2 reset outputs", {req, xfer_busy, xfer_done}, 0);
    rst_n = 1;
    @(negedge clk);

    foreach (VECS[i]) run_xfer(VECS[i]);

    // R3: locked write dropped
    write_code(3'd1, 1'b0);
    write_code(3'd3, 1'b1);
    chk(cfg_code == 3'd1, "R3 locked write ignored", cfg_code, 1);

    // R4: zero-beat start ignored
    start(0, 32'h9000);
    @(negedge clk);
    chk(!xfer_busy && !req, "R4 zero start ignored", xfer_busy, 0);

    // R5 gate and R10 pending beats, code 1 (4 beats), 8-beat transfer
    fifo_level = LVW'(DEPTH - 3);
    start(8, 32'hA000);
    repeat (6) @(negedge clk);
    chk(!req, "R5 gated by FIFO space", req, 0);
    fifo_level = LVW'(DEPTH - 4);
    @(negedge clk);
    chk(req, "R5 released on space", req, 1);
    fifo_level = 0;
    // R4: start while busy ignored
    start(5, 32'hF000);
    chk(req && req_addr == 32'hA000, "R4 busy start ignored", req_addr, 32'hA000);
    ack_once();
    feed(3);
    repeat (4) @(negedge clk);
    chk(!req, "R10 waits for all beats", req, 0);
    feed(1);
    chk(!req, "R10 no request same cycle", req, 0);
    @(negedge clk);
    chk(req && req_addr == 32'hA010, "R10 next request after beats", req_addr, 32'hA010);
    ack_once();
    chk(xfer_done, "R11 done after final ack", xfer_done, 1);
    feed(4);
    @(negedge clk);
    chk(!xfer_busy, "R4 idle at end", xfer_busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule